// File: doc/BRIEF.md
# PWM Channel with Trip-Driven Reference Clear

This block is one output-compare channel of an up-counting timer. It runs in edge-aligned PWM: the reference level is high while the counter is below the compare value and low from there to the end of the period. The counter returns to zero after it reaches the wrap value, and that return is the update event. A trip path can pull the reference low at any time, for example from an analog comparator that watches coil or switch current. The cut acts combinationally within the cycle in which the trip rises. Once cut, the reference stays low until an update event finds the trip inactive.

The trip can come from two places. The first is one of eight dedicated trip pins, picked by a 3-bit selector. The second is the external trigger line after polarity inversion and a run-length digital filter. A one-bit source select chooses between them, and a per-channel enable decides whether the trip may touch the reference at all. The external-trigger source counts as valid only when its divider field is zero and its use as a counter clock is off. When either setting is wrong, that source never trips the channel. A build-time parameter can remove the selector, and the trip then always comes from the conditioned external trigger.

No data stream flows through the block, so it has no valid/ready handshake. Every pin is a plain level-sampled control or status signal.

Top module: `pwm_refclr_channel`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `count` goes to 0 and `pwm_ref` goes to 0.
- R2: When `cnt_en` is 1, `count` rises by 1 each clock until it is greater than or equal to `period_max`, and on the next clock it becomes 0 (the update event). When `cnt_en` is 0, `count` holds.
- R3: With no trip active, `pwm_ref` is 1 exactly while `count < cmp_val`. A compare value of 0 gives a constant low, and a compare value above `period_max` gives a constant high.
- R4: With `trip_src` = 0 and `trip_en` = 1, `pwm_ref` drops to 0 in the same cycle that `trip_in[trip_sel]` is 1, with no clock edge needed. Bit i of `trip_in` is selected by `trip_sel` = i.
- R5: With `trip_src` = 1, the trip follows the conditioned external trigger, and the `trip_in` pins have no effect on `pwm_ref`.
- R6: With `trip_en` = 0, no trip source has any effect on `pwm_ref`.
- R7: Once a trip is seen at a clock edge with `trip_en` = 1, `pwm_ref` stays 0 after the trip falls, until an update event at which the trip is inactive. If the trip is still active at that update event, `pwm_ref` stays 0 for the whole next period.
- R8: The conditioned trigger is `xtrig_raw` XOR `xtrig_inv`, so with `xtrig_inv` = 1 a low `xtrig_raw` is an active trip.
- R9: With `xtrig_flt_len` = N (1 to 15), the filtered trigger takes a new level only after N consecutive clock samples at that level. A shorter pulse has no effect. Reset leaves the filtered level at 0.
- R10: With `xtrig_flt_len` = 0, the filter is bypassed and the filtered trigger follows the polarity-adjusted input combinationally.
- R11: The external-trigger source can trip only while `xtrig_div` = 2'b00 and `xtrig_clk_en` = 0. Otherwise it is treated as inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter run enable |
| period_max | input | CNT_W | Value at which the counter wraps to 0 |
| cmp_val | input | CNT_W | Compare value for PWM |
| trip_en | input | 1 | Per-channel trip enable |
| trip_src | input | 1 | 0: dedicated pin selector, 1: conditioned external trigger |
| trip_sel | input | SEL_W | Index of the dedicated trip pin |
| trip_in | input | N_SRC | Dedicated trip pins, active high |
| xtrig_raw | input | 1 | External trigger line, unfiltered |
| xtrig_inv | input | 1 | Invert external trigger |
| xtrig_flt_len | input | FLT_W | Filter run length, 0 = bypass |
| xtrig_div | input | 2 | External trigger divider setting; must be 00 for tripping |
| xtrig_clk_en | input | 1 | External trigger used as counter clock; must be 0 for tripping |
| count | output | CNT_W | Counter value |
| pwm_ref | output | 1 | Channel reference output |

## Verification
The hardest situation to reach from the ports is a trip that is still active exactly at the update event. Reaching it needs the trip raised late in one period and held across the wrap. The bench watches `count` at falling edges, raises a dedicated trip pin when the counter is one step short of the wrap value, and releases it only after the counter reads 0. It then shows that the reference stays low through the middle of the new period and comes back only at the following wrap. The filter is driven the same way: pulses one sample shorter than the programmed run are placed between falling edges, and a pulse of the full length follows.

// File: rtl/pwm_refclr_pkg.sv
package pwm_refclr_pkg;

  typedef enum logic {
    TRIP_FROM_PINS  = 1'b0,
    TRIP_FROM_XTRIG = 1'b1
  } trip_src_e;

  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_N_SRC = 8;
  localparam int unsigned DEF_FLT_W = 4;

  // The external trigger may only trip when it is neither divided nor used as a clock.
  function automatic logic xtrig_usable(input logic [1:0] div, input logic clk_use);
    return (div == 2'b00) && !clk_use;
  endfunction

endpackage

// File: rtl/refclr_xtrig_cond.sv
module refclr_xtrig_cond #(
  parameter int unsigned FLT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtrig_raw,
  input  logic             xtrig_inv,
  input  logic [FLT_W-1:0] flt_len,
  output logic             xtrig_f
);
  localparam logic [FLT_W-1:0] ONE = {{(FLT_W-1){1'b0}}, 1'b1};

  logic             sample;
  logic             lvl_q;
  logic [FLT_W-1:0] run_q;
  logic             bypass;

  assign sample = xtrig_raw ^ xtrig_inv;
  assign bypass = (flt_len == '0);

  // Run-length filter: run_q counts consecutive samples that differ from lvl_q.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      run_q <= '0;
    end else if (bypass) begin
      lvl_q <= sample;
      run_q <= '0;
    end else if (sample == lvl_q) begin
      run_q <= '0;
    end else if (run_q == flt_len - ONE) begin
      lvl_q <= sample;
      run_q <= '0;
    end else begin
      run_q <= run_q + ONE;
    end
  end

  assign xtrig_f = bypass ? sample : lvl_q;

endmodule

// File: rtl/refclr_src_sel.sv
module refclr_src_sel
  import pwm_refclr_pkg::*;
#(
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned SEL_W       = 3,
  parameter bit          HAS_SEL_MUX = 1'b1
) (
  input  logic [N_SRC-1:0] trip_in,
  input  logic [SEL_W-1:0] trip_sel,
  input  trip_src_e        trip_src,
  input  logic             xtrig_f,
  input  logic [1:0]       xtrig_div,
  input  logic             xtrig_clk_en,
  output logic             trip_int
);
  logic xtrig_trip;

  assign xtrig_trip = xtrig_f & xtrig_usable(xtrig_div, xtrig_clk_en);

  generate
    if (HAS_SEL_MUX) begin : g_mux
      logic pin_trip;
      always_comb begin
        pin_trip = 1'b0;
        for (int i = 0; i < int'(N_SRC); i++) begin
          if (trip_sel == SEL_W'(i)) pin_trip = trip_in[i];
        end
      end
      assign trip_int = (trip_src == TRIP_FROM_XTRIG) ? xtrig_trip : pin_trip;
    end else begin : g_direct
      logic unused_sel;
      assign unused_sel = ^{trip_in, trip_sel, trip_src};
      assign trip_int   = xtrig_trip;
    end
  endgenerate

endmodule

// File: rtl/refclr_pwm_core.sv
module refclr_pwm_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] period_max,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             trip_en,
  input  logic             trip_int,
  output logic [CNT_W-1:0] count,
  output logic             pwm_ref
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             upd;
  logic             lvl_q;
  logic             hold_q;
  logic             trip_live;

  assign upd       = cnt_en && (cnt_q >= period_max);
  assign trip_live = trip_en & trip_int;

  always_comb begin
    if (!cnt_en)  cnt_nxt = cnt_q;
    else if (upd) cnt_nxt = '0;
    else          cnt_nxt = cnt_q + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      lvl_q <= (cnt_nxt < cmp_val);
    end
  end

  // Cleared state persists until an update event sees the trip inactive.
  always_ff @(posedge clk) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (!trip_en) hold_q <= 1'b0;
    else if (upd)     hold_q <= trip_int;
    else if (trip_int) hold_q <= 1'b1;
  end

  assign count   = cnt_q;
  assign pwm_ref = lvl_q & ~(trip_live | (trip_en & hold_q));

endmodule

// File: rtl/pwm_refclr_channel.sv
module pwm_refclr_channel
  import pwm_refclr_pkg::*;
#(
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned N_SRC       = DEF_N_SRC,
  parameter int unsigned FLT_W       = DEF_FLT_W,
  parameter bit          HAS_SEL_MUX = 1'b1,
  localparam int unsigned SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] period_max,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             trip_en,
  input  logic             trip_src,
  input  logic [SEL_W-1:0] trip_sel,
  input  logic [N_SRC-1:0] trip_in,
  input  logic             xtrig_raw,
  input  logic             xtrig_inv,
  input  logic [FLT_W-1:0] xtrig_flt_len,
  input  logic [1:0]       xtrig_div,
  input  logic             xtrig_clk_en,
  output logic [CNT_W-1:0] count,
  output logic             pwm_ref
);
  logic xtrig_f;
  logic trip_int;

  refclr_xtrig_cond #(.FLT_W(FLT_W)) u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtrig_raw (xtrig_raw),
    .xtrig_inv (xtrig_inv),
    .flt_len   (xtrig_flt_len),
    .xtrig_f   (xtrig_f)
  );

  refclr_src_sel #(
    .N_SRC       (N_SRC),
    .SEL_W       (SEL_W),
    .HAS_SEL_MUX (HAS_SEL_MUX)
  ) u_sel (
    .trip_in      (trip_in),
    .trip_sel     (trip_sel),
    .trip_src     (trip_src_e'(trip_src)),
    .xtrig_f      (xtrig_f),
    .xtrig_div    (xtrig_div),
    .xtrig_clk_en (xtrig_clk_en),
    .trip_int     (trip_int)
  );

  refclr_pwm_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .period_max (period_max),
    .cmp_val    (cmp_val),
    .trip_en    (trip_en),
    .trip_int   (trip_int),
    .count      (count),
    .pwm_ref    (pwm_ref)
  );

endmodule

// File: rtl/pwm_refclr_chk.sv
module pwm_refclr_chk #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned FLT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic [CNT_W-1:0] period_max,
  input logic [CNT_W-1:0] cmp_val,
  input logic             trip_en,
  input logic             trip_src,
  input logic             xtrig_raw,
  input logic             xtrig_inv,
  input logic [FLT_W-1:0] xtrig_flt_len,
  input logic [1:0]       xtrig_div,
  input logic             xtrig_clk_en,
  input logic [CNT_W-1:0] count,
  input logic             pwm_ref,
  input logic             trip_int,
  input logic             xtrig_f
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (count == '0) && !pwm_ref); // R1
  AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && (count >= period_max) |=> count == '0); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && (count < period_max) |=> count == $past(count) + 1'b1); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count)); // R2
  AST_PWM_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !trip_en && $stable(cmp_val) |-> pwm_ref == (count < cmp_val)); // R3
  AST_TRIP_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    trip_en && trip_int |-> !pwm_ref); // R4
  AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    armed && trip_en && $past(trip_en && trip_int) |-> !pwm_ref); // R7
  AST_FLT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (xtrig_flt_len != '0) && !$stable(xtrig_f) |-> xtrig_f == $past(xtrig_raw ^ xtrig_inv)); // R9
  AST_XTRIG_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    trip_src && ((xtrig_div != 2'b00) || xtrig_clk_en) |-> !trip_int); // R11
  AST_XTRIG_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_src && (xtrig_flt_len == '0) && (xtrig_div == 2'b00) && !xtrig_clk_en
      |-> trip_int == (xtrig_raw ^ xtrig_inv)); // R10

endmodule

bind pwm_refclr_channel pwm_refclr_chk #(.CNT_W(CNT_W), .FLT_W(FLT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cnt_en        (cnt_en),
  .period_max    (period_max),
  .cmp_val       (cmp_val),
  .trip_en       (trip_en),
  .trip_src      (trip_src),
  .xtrig_raw     (xtrig_raw),
  .xtrig_inv     (xtrig_inv),
  .xtrig_flt_len (xtrig_flt_len),
  .xtrig_div     (xtrig_div),
  .xtrig_clk_en  (xtrig_clk_en),
  .count         (count),
  .pwm_ref       (pwm_ref),
  .trip_int      (trip_int),
  .xtrig_f       (xtrig_f)
);

// File: tb/sim_pwm_refclr_channel.sv
module sim_pwm_refclr_channel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b1;
  logic [15:0] period_max = 16'd9;
  logic [15:0] cmp_val = 16'd4;
  logic        trip_en = 1'b0;
  logic        trip_src = 1'b0;
  logic [2:0]  trip_sel = 3'd0;
  logic [7:0]  trip_in = 8'h00;
  logic        xtrig_raw = 1'b0;
  logic        xtrig_inv = 1'b0;
  logic [3:0]  xtrig_flt_len = 4'd0;
  logic [1:0]  xtrig_div = 2'b00;
  logic        xtrig_clk_en = 1'b0;
  logic [15:0] count;
  logic        pwm_ref;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_refclr_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .period_max(period_max),
    .cmp_val(cmp_val), .trip_en(trip_en), .trip_src(trip_src),
    .trip_sel(trip_sel), .trip_in(trip_in), .xtrig_raw(xtrig_raw),
    .xtrig_inv(xtrig_inv), .xtrig_flt_len(xtrig_flt_len),
    .xtrig_div(xtrig_div), .xtrig_clk_en(xtrig_clk_en),
    .count(count), .pwm_ref(pwm_ref)
  );

  typedef struct packed {
    logic [15:0] pmax;
    logic [15:0] cmp;
    logic        ten;
    logic [2:0]  sel;
    logic [7:0]  pins;
    logic [15:0] exp_high;
  } vec_t;

  // Stimulus for R3, R4 and R6: high cycles expected in one full period.
  localparam vec_t VEC [9] = '{
    '{16'd9, 16'd4,  1'b0, 3'd0, 8'h00, 16'd4},
    '{16'd9, 16'd0,  1'b0, 3'd0, 8'h00, 16'd0},
    '{16'd9, 16'd10, 1'b0, 3'd0, 8'h00, 16'd10},
    '{16'd9, 16'd15, 1'b0, 3'd0, 8'h00, 16'd10},
    '{16'd5, 16'd3,  1'b1, 3'd2, 8'h04, 16'd0},
    '{16'd5, 16'd3,  1'b1, 3'd2, 8'hFB, 16'd3},
    '{16'd5, 16'd3,  1'b0, 3'd2, 8'hFF, 16'd3},
    '{16'd7, 16'd7,  1'b1, 3'd7, 8'h7F, 16'd7},
    '{16'd7, 16'd7,  1'b1, 3'd7, 8'h80, 16'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (int'(count) != v);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 count in reset", int'(count), 0);
    chk("R1 pwm_ref in reset", int'(pwm_ref), 0);

    // Table walk: R3 levels, R4 pin trips, R6 trip disabled
    for (int v = 0; v < 9; v++) begin
      int high;
      period_max = VEC[v].pmax; cmp_val = VEC[v].cmp; trip_en = VEC[v].ten;
      trip_sel = VEC[v].sel; trip_in = VEC[v].pins; trip_src = 1'b0;
      do_reset();
      repeat (int'(VEC[v].pmax) + 1) @(negedge clk);
      high = 0;
      for (int k = 0; k <= int'(VEC[v].pmax); k++) begin
        @(negedge clk);
        if (pwm_ref) high++;
      end
      chk($sformatf("R3/R4/R6 vector %0d high cycles", v), high, int'(VEC[v].exp_high));
    end

    // R2: counting, wrap and hold
    trip_en = 1'b0; trip_in = 8'h00; period_max = 16'd4; cmp_val = 16'd2;
    do_reset();
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      chk("R2 count sequence", int'(count), k % 5);
    end
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 hold when disabled", int'(count), 0);
    cnt_en = 1'b1;

    // R4 same-cycle cut, R7 hold until update
    period_max = 16'd9; cmp_val = 16'd9; trip_en = 1'b1; trip_src = 1'b0;
    trip_sel = 3'd3; trip_in = 8'h00;
    do_reset();
    wait_cnt(1);
    chk("R4 high before trip", int'(pwm_ref), 1);
    trip_in = 8'h08;
    #1 chk("R4 same-cycle cut", int'(pwm_ref), 0);
    @(posedge clk); #1 trip_in = 8'h00;
    @(negedge clk);
    chk("R7 stays low after trip falls", int'(pwm_ref), 0);
    wait_cnt(0);
    chk("R7 released at update", int'(pwm_ref), 1);

    // R7 trip active across update event
    wait_cnt(8);
    trip_in = 8'h08;
    wait_cnt(0);
    trip_in = 8'h00;
    #1 chk("R7 low at period start", int'(pwm_ref), 0);
    wait_cnt(5);
    chk("R7 low through next period", int'(pwm_ref), 0);
    wait_cnt(0);
    chk("R7 released one period later", int'(pwm_ref), 1);

    // R5 and R10: external trigger source, filter bypassed
    trip_src = 1'b1; trip_in = 8'hFF; xtrig_raw = 1'b0; xtrig_flt_len = 4'd0;
    do_reset();
    wait_cnt(2);
    chk("R5 pins ignored", int'(pwm_ref), 1);
    xtrig_raw = 1'b1;
    #1 chk("R10 unfiltered trip cut", int'(pwm_ref), 0);
    xtrig_raw = 1'b0;
    wait_cnt(0);
    chk("R10 release after update", int'(pwm_ref), 1);

    // R8: inverted polarity
    xtrig_inv = 1'b1;
    #1 chk("R8 low input trips when inverted", int'(pwm_ref), 0);
    xtrig_raw = 1'b1;
    wait_cnt(0);
    chk("R8 high input idle when inverted", int'(pwm_ref), 1);
    xtrig_inv = 1'b0; xtrig_raw = 1'b0;

    // R11: divider or clock use blocks the trigger trip
    xtrig_raw = 1'b1; xtrig_div = 2'b01;
    wait_cnt(3);
    chk("R11 blocked by divider", int'(pwm_ref), 1);
    xtrig_div = 2'b00; xtrig_clk_en = 1'b1;
    @(negedge clk);
    chk("R11 blocked by clock use", int'(pwm_ref), 1);
    xtrig_clk_en = 1'b0;
    #1 chk("R11 trip once usable", int'(pwm_ref), 0);
    xtrig_raw = 1'b0;
    wait_cnt(0);

    // R9: run-length filter of 3 samples, reference always high
    cmp_val = 16'd20; xtrig_flt_len = 4'd3; xtrig_raw = 1'b0;
    do_reset();
    @(negedge clk);
    xtrig_raw = 1'b1;
    @(negedge clk); chk("R9 one sample ignored", int'(pwm_ref), 1);
    @(negedge clk); chk("R9 two samples ignored", int'(pwm_ref), 1);
    xtrig_raw = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R9 short pulse no effect", int'(pwm_ref), 1);
    end
    xtrig_raw = 1'b1;
    @(negedge clk); chk("R9 first of three", int'(pwm_ref), 1);
    @(negedge clk); chk("R9 second of three", int'(pwm_ref), 1);
    @(negedge clk); chk("R9 accepted after three", int'(pwm_ref), 0);
    xtrig_raw = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule